// File: doc/BRIEF.md
# Power-Management Tick Timer

This block is a free-running counter that sits in a small power-management register space. A periodic tick-enable input, nominally 3,579,545 pulses per second and generated elsewhere, advances it. A configuration word written over the register port picks narrow (`NARROW_W`, default 24 bits) or wide (`WIDE_W`, default 32 bits) counting. The same word can also freeze the count or force it to zero. Software reads the count at the timer offset as one word. In narrow mode the bits above the narrow width always read as zero.

Three bits of the configuration word control the counter: bit 6 is the freeze control, bit 11 selects wide mode and bit 14 is the clear control. A small state machine holds the counter mode. It has three states: `CNT_RUN` (counts ticks), `CNT_HOLD` (frozen) and `CNT_ZERO` (held at zero). The state changes only on a write to the configuration address. Transitions go to `CNT_ZERO` when the written word has bit 14 set. Otherwise they go to `CNT_HOLD` when bit 6 is set. Otherwise they go to `CNT_RUN`. Every state can reach every other state, including itself, in one write. The counter acts on the new state from the clock edge after the write.

Top module: `pmt_timer`

## Requirements
- R1: In `CNT_RUN` the count increases by one on each clock edge where `tick_en` is high, and it holds on each edge where `tick_en` is low.
- R2: In narrow mode (bit 11 clear) the count wraps from 2^NARROW_W-1 to 0.
- R3: In wide mode (bit 11 set) the count wraps from 2^WIDE_W-1 to 0.
- R4: While bit 6 is set (and bit 14 clear) the count holds its value whatever `tick_en` does. After bit 6 clears, counting resumes from the held value.
- R5: While bit 14 is set the count is zero from the edge after the write, regardless of bit 6 or `tick_en`.
- R6: A read with `reg_sel` = `TMR_ADDR` (default 0x08) returns the count zero-extended to `DATA_W`. In narrow mode the bits at and above NARROW_W read as zero. The whole word comes from one count register.
- R7: After a switch from wide to narrow mode, the first counted tick discards the bits at and above NARROW_W. A later return to wide mode shows them cleared.
- R8: A read at `CFG_ADDR` (default 0x40) returns bits 6, 11 and 14 as last written and zero elsewhere. Writes to the timer address have no effect on the count.
- R9: After reset the block is in `CNT_RUN`, narrow mode, with the count at zero. Reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timing-reference tick enable, one cycle per count |
| reg_sel | input | ADDR_W | Register select (timer word or configuration word) |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the selected register, combinational |

## Verification
The bench builds the block with narrow and wide widths of 8 and 12 bits, so both wrap points can be reached. A counter that ignored its mode would run past 0xFF in narrow mode or stop at 0xFF in wide mode. The wide-to-narrow switch is tested with a value whose upper bits are set. A design that only masks on read would show 0x400 instead of 0 when wide mode returns. The clear and freeze bits are written together to prove that clear wins; a reversed priority would leave the frozen count visible. Writes to the timer word are checked against the running count, and the configuration readback is checked with all bits written as one, so stray writable bits or a writable timer show up as wrong read values.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    // Configuration bit positions decoded by the mode state machine
    localparam int FREEZE_BIT = 6;
    localparam int WIDE_BIT   = 11;
    localparam int CLEAR_BIT  = 14;

    typedef enum logic [1:0] {
        CNT_RUN  = 2'd0,
        CNT_HOLD = 2'd1,
        CNT_ZERO = 2'd2
    } cnt_state_e;

endpackage

// File: rtl/pmt_mode_fsm.sv
module pmt_mode_fsm
    import pmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       freeze_in,
    input  logic       wide_in,
    input  logic       clear_in,
    output cnt_state_e state,
    output logic       wide_mode,
    output logic       freeze_bit,
    output logic       clear_bit
);

    cnt_state_e state_q, state_d;
    logic       wide_q, freeze_q, clear_q;

    // next-state decode: clear dominates freeze
    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            unique case ({clear_in, freeze_in})
                2'b10, 2'b11: state_d = CNT_ZERO;
                2'b01:        state_d = CNT_HOLD;
                default:      state_d = CNT_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CNT_RUN;
            wide_q   <= 1'b0;
            freeze_q <= 1'b0;
            clear_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cfg_we) begin
                wide_q   <= wide_in;
                freeze_q <= freeze_in;
                clear_q  <= clear_in;
            end
        end
    end

    // outputs
    always_comb begin
        state      = state_q;
        wide_mode  = wide_q;
        freeze_bit = freeze_q;
        clear_bit  = clear_q;
    end

endmodule

// File: rtl/pmt_count_core.sv
module pmt_count_core
    import pmt_pkg::*;
#(
    parameter int NARROW_W = 24,
    parameter int WIDE_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  cnt_state_e        state,
    input  logic              wide_mode,
    output logic [WIDE_W-1:0] count
);

    logic [WIDE_W-1:0]   cnt_q, cnt_next;
    logic [NARROW_W-1:0] lo_inc;

    always_comb begin
        lo_inc = cnt_q[NARROW_W-1:0] + 1'b1;
        if (wide_mode) cnt_next = cnt_q + 1'b1;
        else           cnt_next = WIDE_W'(lo_inc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state)
                CNT_ZERO: cnt_q <= '0;
                CNT_HOLD: cnt_q <= cnt_q;
                CNT_RUN:  if (tick_en) cnt_q <= cnt_next;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/pmt_reg_read.sv
module pmt_reg_read
    import pmt_pkg::*;
#(
    parameter int          NARROW_W = 24,
    parameter int          WIDE_W   = 32,
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  TMR_ADDR = 8'h08,
    parameter logic [7:0]  CFG_ADDR = 8'h40
) (
    input  logic [ADDR_W-1:0] reg_sel,
    input  logic [WIDE_W-1:0] count,
    input  logic              wide_mode,
    input  logic              freeze_bit,
    input  logic              clear_bit,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] TMR_SEL = ADDR_W'(TMR_ADDR);
    localparam logic [ADDR_W-1:0] CFG_SEL = ADDR_W'(CFG_ADDR);

    always_comb begin
        rd_data = '0;
        if (reg_sel == TMR_SEL) begin
            if (wide_mode) rd_data = DATA_W'(count);
            else           rd_data = DATA_W'(count[NARROW_W-1:0]);
        end else if (reg_sel == CFG_SEL) begin
            rd_data[FREEZE_BIT] = freeze_bit;
            rd_data[WIDE_BIT]   = wide_mode;
            rd_data[CLEAR_BIT]  = clear_bit;
        end
    end

endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
    import pmt_pkg::*;
#(
    parameter int         NARROW_W = 24,
    parameter int         WIDE_W   = 32,
    parameter int         DATA_W   = 32,
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] TMR_ADDR = 8'h08,
    parameter logic [7:0] CFG_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] CFG_SEL = ADDR_W'(CFG_ADDR);

    cnt_state_e        state_q;
    logic              wide_q, freeze_q, clear_q, cfg_we;
    logic [WIDE_W-1:0] cnt_q;

    assign cfg_we = wr_en && (reg_sel == CFG_SEL);

    pmt_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .freeze_in  (wr_data[FREEZE_BIT]),
        .wide_in    (wr_data[WIDE_BIT]),
        .clear_in   (wr_data[CLEAR_BIT]),
        .state      (state_q),
        .wide_mode  (wide_q),
        .freeze_bit (freeze_q),
        .clear_bit  (clear_q)
    );

    pmt_count_core #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .state     (state_q),
        .wide_mode (wide_q),
        .count     (cnt_q)
    );

    pmt_reg_read #(
        .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .DATA_W(DATA_W),
        .ADDR_W(ADDR_W), .TMR_ADDR(TMR_ADDR), .CFG_ADDR(CFG_ADDR)
    ) u_read (
        .reg_sel    (reg_sel),
        .count      (cnt_q),
        .wide_mode  (wide_q),
        .freeze_bit (freeze_q),
        .clear_bit  (clear_q),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/pmt_timer_chk.sv
module pmt_timer_chk
    import pmt_pkg::*;
#(
    parameter int         NARROW_W = 24,
    parameter int         WIDE_W   = 32,
    parameter int         DATA_W   = 32,
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] TMR_ADDR = 8'h08
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input cnt_state_e        state_q,
    input logic              wide_q,
    input logic [WIDE_W-1:0] cnt_q,
    input logic [ADDR_W-1:0] reg_sel,
    input logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] TMR_SEL = ADDR_W'(TMR_ADDR);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && !tick_en) |=> $stable(cnt_q));

    p_wide_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && tick_en && wide_q) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_HOLD) |=> $stable(cnt_q));

    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_ZERO) |=> (cnt_q == '0));

    p_narrow_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == TMR_SEL && !wide_q) |-> (rd_data[DATA_W-1:NARROW_W] == '0));

    p_narrow_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && tick_en && !wide_q) |=> (cnt_q[WIDE_W-1:NARROW_W] == '0));

endmodule

bind pmt_timer pmt_timer_chk #(
    .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .TMR_ADDR(TMR_ADDR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .state_q (state_q),
    .wide_q  (wide_q),
    .cnt_q   (cnt_q),
    .reg_sel (reg_sel),
    .rd_data (rd_data)
);

// File: tb/test_pmt_timer.sv
module test_pmt_timer;

    localparam int NW = 8;
    localparam int WW = 12;
    localparam logic [7:0] TMR = 8'h08;
    localparam logic [7:0] CFG = 8'h40;
    localparam logic [31:0] C_STOP = 32'h0000_0040;
    localparam logic [31:0] C_WIDE = 32'h0000_0800;
    localparam logic [31:0] C_CLR  = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  reg_sel = 8'h00;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pmt_timer #(.NARROW_W(NW), .WIDE_W(WW)) i_pmt_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_sel(reg_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_sel = a;
        #1 v = rd_data;
    endtask

    task automatic clear_cnt(input logic [31:0] mode);
        write_reg(CFG, C_CLR | mode);
        write_reg(CFG, mode);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        read_reg(TMR, v);  check("R9 count after reset", v, 32'h0);
        read_reg(CFG, v);  check("R9 config after reset", v, 32'h0);
        read_reg(8'h10, v); check("R9 unmapped read", v, 32'h0);
    endtask

    task automatic t_count;
        logic [31:0] v;
        run_ticks(5);
        read_reg(TMR, v); check("R1 five ticks", v, 32'd5);
        idle(3);
        read_reg(TMR, v); check("R1 hold without tick", v, 32'd5);
    endtask

    task automatic t_narrow_wrap;
        logic [31:0] v;
        clear_cnt(32'h0);
        run_ticks(255);
        read_reg(TMR, v); check("R2 narrow max", v, 32'hFF);
        run_ticks(1);
        read_reg(TMR, v); check("R2 narrow wrap", v, 32'h0);
        run_ticks(3);
        read_reg(TMR, v); check("R2 after wrap", v, 32'h3);
    endtask

    task automatic t_wide_wrap;
        logic [31:0] v;
        clear_cnt(C_WIDE);
        run_ticks(4095);
        read_reg(TMR, v); check("R3 wide max", v, 32'hFFF);
        run_ticks(1);
        read_reg(TMR, v); check("R3 wide wrap", v, 32'h0);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        clear_cnt(C_WIDE);
        run_ticks(10);
        write_reg(CFG, C_WIDE | C_STOP);
        run_ticks(20);
        read_reg(TMR, v); check("R4 frozen", v, 32'd10);
        write_reg(CFG, C_WIDE);
        run_ticks(2);
        read_reg(TMR, v); check("R4 resume", v, 32'd12);
    endtask

    task automatic t_clear_prio;
        logic [31:0] v;
        write_reg(CFG, C_WIDE | C_STOP | C_CLR);
        idle(1);
        read_reg(TMR, v); check("R5 clear over stop", v, 32'h0);
        run_ticks(5);
        read_reg(TMR, v); check("R5 zero with ticks", v, 32'h0);
        write_reg(CFG, C_WIDE);
        run_ticks(3);
        read_reg(TMR, v); check("R5 count after release", v, 32'd3);
    endtask

    task automatic t_mode_switch;
        logic [31:0] v;
        clear_cnt(C_WIDE);
        run_ticks(1023);
        read_reg(TMR, v); check("R6 wide read", v, 32'h3FF);
        write_reg(CFG, 32'h0);
        read_reg(TMR, v); check("R6 narrow read masked", v, 32'hFF);
        run_ticks(1);
        write_reg(CFG, C_WIDE);
        read_reg(TMR, v); check("R7 upper bits dropped", v, 32'h0);
    endtask

    task automatic t_cfg_access;
        logic [31:0] v;
        write_reg(CFG, 32'hFFFF_FFFF);
        read_reg(CFG, v); check("R8 config readback", v, 32'h0000_4840);
        clear_cnt(C_WIDE);
        run_ticks(7);
        write_reg(TMR, 32'h0000_0ABC);
        read_reg(TMR, v); check("R8 timer write ignored", v, 32'd7);
        read_reg(CFG, v); check("R8 config unchanged", v, C_WIDE);
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_narrow_wrap();
        t_wide_wrap();
        t_stop();
        t_clear_prio();
        t_mode_switch();
        t_cfg_access();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule